// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block follows where endpoint 0 of a USB device stands inside a control transfer. Logic upstream decodes tokens, handshakes and packet sizes. It presents them to this block as one-cycle event strobes, together with the direction bit and the length field of the setup request. From these events the block keeps a 3-bit stage code and raises a stage-change interrupt flag, which software clears by writing zero. When the host breaks the legal order of tokens, the block drives the endpoint-0 response field to stall.

A transfer starts when the setup stage completes. The request then picks a read data stage, a write data stage or, when the length is zero, a write status stage with no data. The data stage ends when the host issues a token in the opposite direction, and the status stage ends on its ACK. If the host sends an illegal token, a non-empty packet in a read status stage, or a packet larger than the endpoint allows, the block enters the sequence-error stage. A mode input picks how that error is held. In sticky mode the error code stays until software clears the flag. Otherwise the next setup token ends the error.

All pins are plain control and status signals. There is no data stream at the edge, so there is no valid/ready handshake and no back-pressure. Each event input is a single-cycle pulse, and at most one token or handshake event arrives per cycle.

Top module: `ctl_stage_tracker`

## Requirements
- R1: A synchronous active-low reset gives stage code 000, interrupt flag 0 and response field 00.
- R2: In stage 000, a setup-completion strobe moves the stage to 001 (read data) when the direction bit is 1 (device-to-host) and the length is nonzero. It moves to 011 (write data) when the direction bit is 0 and the length is nonzero, and to 101 (write status, no data) when the length is zero.
- R3: In stage 001, an OUT token moves to 010 (read status) once at least one IN transaction of that stage has ended with an ACK.
- R4: In stages 010, 100 and 101, an ACK handshake returns the stage to 000.
- R5: In stage 011, an IN token moves to 100 (write status) once at least one OUT transaction of that stage has been ACKed. Any number of further OUT transactions beyond the requested length is accepted without error.
- R6: Each of these is a read-side sequence error: an OUT token in 001 before any ACKed IN; an IN token in 010; a data packet in 010 whose zero-length indicator is 0. A data packet in 010 with the zero-length indicator at 1 is accepted.
- R7: Each of these is a write-side sequence error: an IN token in 011 before any ACKed OUT; an OUT token in 100 or 101.
- R8: An oversize-packet strobe in any stage other than 110 is a sequence error. A sequence error sets stage 110, sets the response field to 10 (stall) and sets the interrupt flag. The response field returns to 00 when the stage leaves 110.
- R9: In sticky mode, stage 110 holds through setup tokens and setup completions until a clear strobe. The clear strobe moves the stage to 000 and clears the flag.
- R10: With sticky mode off, a setup token in stage 110 moves the stage to 000 at once.
- R11: The interrupt flag is set on every setup completion and on every stage change out of a non-error stage. Changes out of 110 do not set it. A clear strobe clears it, but a set event in the same cycle wins.
- R12: A setup token in any stage other than 110 aborts the transfer and returns the stage to 000.
- R13: The reserved code 111 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sticky_err_en | input | 1 | 1 holds the error stage until software clears the flag |
| setup_done | input | 1 | Strobe: setup stage completed |
| setup_tok | input | 1 | Strobe: setup token received |
| in_tok | input | 1 | Strobe: IN token received |
| out_tok | input | 1 | Strobe: OUT token received |
| hs_ack | input | 1 | Strobe: transaction closed by an ACK handshake |
| rx_data | input | 1 | Strobe: data packet received |
| rx_zlp | input | 1 | Qualifies rx_data: the packet had zero length |
| rx_oversize | input | 1 | Strobe: packet exceeded the endpoint maximum size |
| req_dir_in | input | 1 | Request direction, 1 = device-to-host |
| req_len | input | LEN_W | Request length field |
| flag_clr | input | 1 | Strobe: software writes 0 to the interrupt flag |
| stage | output | 3 | Current stage code |
| stage_irq | output | 1 | Stage-change interrupt flag |
| ep0_resp | output | 2 | Endpoint-0 response field, 10 = stall |

## Verification
The embedded properties check on every cycle that the reserved code never appears and that stall always goes with the error stage. They also check that the sticky error holds until a clear, that setup tokens abort or release the stage as the mode dictates, that handshakes close status stages, and that the flag follows its set-over-clear rule. The bench scenarios are needed for the rest: the three-way branch at setup completion, the need for an ACKed transaction before a direction change, overlong write data, and each illegal ordering. They walk complete read, write and no-data transfers, show each error path releasing under both modes, and show the interrupt flag value after every step.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;
  localparam int STG_W  = 3;
  localparam int RESP_W = 2;

  typedef enum logic [STG_W-1:0] {
    ST_IDLE      = 3'b000,
    ST_RD_DATA   = 3'b001,
    ST_RD_STAT   = 3'b010,
    ST_WR_DATA   = 3'b011,
    ST_WR_STAT   = 3'b100,
    ST_WR_NODATA = 3'b101,
    ST_SEQ_ERR   = 3'b110,
    ST_RSVD      = 3'b111
  } stage_e;

  typedef struct packed {
    logic setup_done;
    logic setup_tok;
    logic in_tok;
    logic out_tok;
    logic hs_ack;
    logic rx_data;
    logic rx_zlp;
    logic rx_oversize;
  } evt_t;

  localparam logic [RESP_W-1:0] RESP_STALL = 2'b10;
  localparam logic [RESP_W-1:0] RESP_NONE  = 2'b00;
endpackage

// File: rtl/ctl_stage_next.sv
module ctl_stage_next
  import ctl_stage_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  stage_e           cur,
  input  evt_t             ev,
  input  logic             dir_in,
  input  logic [LEN_W-1:0] req_len,
  input  logic             served,
  input  logic             sticky,
  input  logic             clr_req,
  output stage_e           nxt,
  output logic             setup_acc
);
  logic len_zero;
  logic bad_pkt;

  assign len_zero = (req_len == '0);
  assign bad_pkt  = ev.rx_data && !ev.rx_zlp;

  always_comb begin
    nxt       = cur;
    setup_acc = 1'b0;
    if (cur == ST_SEQ_ERR) begin
      if (sticky) begin
        if (clr_req) nxt = ST_IDLE;
      end else if (ev.setup_tok) begin
        nxt = ST_IDLE;
      end
    end else if (ev.setup_tok) begin
      nxt = ST_IDLE;
    end else if (ev.rx_oversize) begin
      nxt = ST_SEQ_ERR;
    end else begin
      case (cur)
        ST_IDLE: begin
          if (ev.setup_done) begin
            setup_acc = 1'b1;
            if (len_zero)    nxt = ST_WR_NODATA;
            else if (dir_in) nxt = ST_RD_DATA;
            else             nxt = ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (ev.out_tok) nxt = served ? ST_RD_STAT : ST_SEQ_ERR;
        end
        ST_RD_STAT: begin
          if (ev.in_tok || bad_pkt) nxt = ST_SEQ_ERR;
          else if (ev.hs_ack)       nxt = ST_IDLE;
        end
        ST_WR_DATA: begin
          if (ev.in_tok) nxt = served ? ST_WR_STAT : ST_SEQ_ERR;
        end
        ST_WR_STAT, ST_WR_NODATA: begin
          if (ev.out_tok)     nxt = ST_SEQ_ERR;
          else if (ev.hs_ack) nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctl_stage_progress.sv
module ctl_stage_progress
  import ctl_stage_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  stage_e cur,
  input  stage_e nxt,
  input  logic   hs_ack,
  output logic   served
);
  logic in_data;
  assign in_data = (cur == ST_RD_DATA) || (cur == ST_WR_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n)          served <= 1'b0;
    else if (nxt != cur) served <= 1'b0;
    else if (in_data && hs_ack) served <= 1'b1;
  end

  // R3
  served_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    served |-> (cur == ST_RD_DATA || cur == ST_WR_DATA));
endmodule

// File: rtl/ctl_irq_flag.sv
module ctl_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_ev)  flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  // R11
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_ev) |=> !flag);
endmodule

// File: rtl/ctl_stage_tracker.sv
module ctl_stage_tracker
  import ctl_stage_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sticky_err_en,
  input  logic             setup_done,
  input  logic             setup_tok,
  input  logic             in_tok,
  input  logic             out_tok,
  input  logic             hs_ack,
  input  logic             rx_data,
  input  logic             rx_zlp,
  input  logic             rx_oversize,
  input  logic             req_dir_in,
  input  logic [LEN_W-1:0] req_len,
  input  logic             flag_clr,
  output logic [2:0]       stage,
  output logic             stage_irq,
  output logic [1:0]       ep0_resp
);
  stage_e            cur_q;
  stage_e            nxt;
  evt_t              ev;
  logic              served;
  logic              setup_acc;
  logic              set_ev;
  logic [RESP_W-1:0] resp_q;

  assign ev = '{setup_done:  setup_done,
                setup_tok:   setup_tok,
                in_tok:      in_tok,
                out_tok:     out_tok,
                hs_ack:      hs_ack,
                rx_data:     rx_data,
                rx_zlp:      rx_zlp,
                rx_oversize: rx_oversize};

  ctl_stage_next #(.LEN_W(LEN_W)) u_next (
    .cur       (cur_q),
    .ev        (ev),
    .dir_in    (req_dir_in),
    .req_len   (req_len),
    .served    (served),
    .sticky    (sticky_err_en),
    .clr_req   (flag_clr),
    .nxt       (nxt),
    .setup_acc (setup_acc)
  );

  ctl_stage_progress u_prog (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur    (cur_q),
    .nxt    (nxt),
    .hs_ack (hs_ack),
    .served (served)
  );

  assign set_ev = setup_acc || ((cur_q != ST_SEQ_ERR) && (nxt != cur_q));

  ctl_irq_flag u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .clr_req (flag_clr),
    .flag    (stage_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= ST_IDLE;
      resp_q <= RESP_NONE;
    end else begin
      cur_q <= nxt;
      if (nxt == ST_SEQ_ERR)       resp_q <= RESP_STALL;
      else if (cur_q == ST_SEQ_ERR) resp_q <= RESP_NONE;
    end
  end

  assign stage    = cur_q;
  assign ep0_resp = resp_q;

  // R13
  no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage != 3'b111);
  // R8
  stall_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'b110) |-> (ep0_resp == 2'b10));
  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'b110 && sticky_err_en && !flag_clr) |=> (stage == 3'b110));
  // R10
  nonsticky_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'b110 && !sticky_err_en && setup_tok) |=> (stage == 3'b000));
  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != 3'b110 && setup_tok) |=> (stage == 3'b000));
  // R4
  status_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage == 3'b101 || stage == 3'b100) && hs_ack && !out_tok
      && !setup_tok && !rx_oversize) |=> (stage == 3'b000));
endmodule

// File: tb/ctl_stage_tracker_test.sv
module ctl_stage_tracker_test;
  localparam int LEN_W = 16;
  localparam int NV    = 51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sticky_err_en = 1'b0;
  logic setup_done = 1'b0, setup_tok = 1'b0, in_tok = 1'b0, out_tok = 1'b0;
  logic hs_ack = 1'b0, rx_data = 1'b0, rx_zlp = 1'b0, rx_oversize = 1'b0;
  logic req_dir_in = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic flag_clr = 1'b0;
  logic [2:0] stage;
  logic stage_irq;
  logic [1:0] ep0_resp;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ctl_stage_tracker #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .sticky_err_en(sticky_err_en),
    .setup_done(setup_done), .setup_tok(setup_tok), .in_tok(in_tok),
    .out_tok(out_tok), .hs_ack(hs_ack), .rx_data(rx_data), .rx_zlp(rx_zlp),
    .rx_oversize(rx_oversize), .req_dir_in(req_dir_in), .req_len(req_len),
    .flag_clr(flag_clr), .stage(stage), .stage_irq(stage_irq),
    .ep0_resp(ep0_resp)
  );

  // fields: sd st in out ack zlp data ovf dir len clr _ stage _ flag _ resp
  typedef struct packed {
    logic sd, st, it, ot, ak, zl, dt, ov, dr, ln, cl;
    logic [2:0] stg;
    logic flg;
    logic [1:0] rsp;
  } vec_t;

  localparam logic [18:0] VEC [NV] = '{
    // R2 R3 R4 read transfer
    19'b10000000110_001_1_00, 19'b00000000001_001_0_00,
    19'b00100000000_001_0_00, 19'b00001000000_001_0_00,
    19'b00010000000_010_1_00, 19'b00000110000_010_1_00,
    19'b00001000000_000_1_00, 19'b00000000001_000_0_00,
    // R5 write transfer, extra OUT beyond length
    19'b10000000010_011_1_00, 19'b00010000000_011_1_00,
    19'b00001000000_011_1_00, 19'b00010000000_011_1_00,
    19'b00001000000_011_1_00, 19'b00100000000_100_1_00,
    19'b00001000000_000_1_00, 19'b00000000001_000_0_00,
    // R2 R4 no-data transfer
    19'b10000000000_101_1_00, 19'b00100000000_101_1_00,
    19'b00001000000_000_1_00,
    // R6 R8 R10 OUT before served IN
    19'b10000000110_001_1_00, 19'b00000000001_001_0_00,
    19'b00010000000_110_1_10, 19'b01000000000_000_1_00,
    19'b00000000001_000_0_00,
    // R6 non-empty packet in read status
    19'b10000000110_001_1_00, 19'b00100000000_001_1_00,
    19'b00001000000_001_1_00, 19'b00010000000_010_1_00,
    19'b00000000001_010_0_00, 19'b00000010000_110_1_10,
    19'b01000000000_000_1_00,
    // R7 IN before ACKed OUT
    19'b10000000010_011_1_00, 19'b00100000000_110_1_10,
    19'b01000000000_000_1_00,
    // R7 OUT in no-data status
    19'b10000000000_101_1_00, 19'b00010000000_110_1_10,
    19'b01000000000_000_1_00,
    // R8 oversize packet
    19'b10000000010_011_1_00, 19'b00000001000_110_1_10,
    19'b01000000000_000_1_00,
    // R6 IN token in read status
    19'b10000000110_001_1_00, 19'b00100000000_001_1_00,
    19'b00001000000_001_1_00, 19'b00010000000_010_1_00,
    19'b00100000000_110_1_10, 19'b01000000000_000_1_00,
    19'b00000000001_000_0_00,
    // R12 abort by setup token, R11 flag on change
    19'b10000000110_001_1_00, 19'b00000000001_001_0_00,
    19'b01000000000_000_1_00, 19'b00000000001_000_0_00
  };

  function automatic string tag_of(input int i);
    if (i < 8)  return "R3";
    if (i < 16) return "R5";
    if (i < 19) return "R4";
    if (i < 31) return "R6";
    if (i < 37) return "R7";
    if (i < 40) return "R8";
    if (i < 47) return "R6";
    return "R12";
  endfunction

  task automatic check(input string tag, input logic [2:0] es, input logic ef,
                       input logic [1:0] er);
    total++;
    if (stage !== es || stage_irq !== ef || ep0_resp !== er) begin
      bad++;
      $display("FAIL %s: stage=%b irq=%b resp=%b expected stage=%b irq=%b resp=%b",
               tag, stage, stage_irq, ep0_resp, es, ef, er);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    setup_done = v.sd; setup_tok = v.st; in_tok = v.it; out_tok = v.ot;
    hs_ack = v.ak; rx_zlp = v.zl; rx_data = v.dt; rx_oversize = v.ov;
    req_dir_in = v.dr; req_len = v.ln ? 16'd64 : 16'd0; flag_clr = v.cl;
    @(posedge clk);
    #5;
    setup_done = 0; setup_tok = 0; in_tok = 0; out_tok = 0; hs_ack = 0;
    rx_zlp = 0; rx_data = 0; rx_oversize = 0; flag_clr = 0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1", 3'b000, 1'b0, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      apply(v);
      check(tag_of(i), v.stg, v.flg, v.rsp);
    end

    // R9 sticky mode holds the error through setup activity
    sticky_err_en = 1'b1;
    apply(vec_t'(19'b10000000010_011_1_00)); check("R2", 3'b011, 1'b1, 2'b00);
    apply(vec_t'(19'b00100000000_110_1_10)); check("R7", 3'b110, 1'b1, 2'b10);
    apply(vec_t'(19'b01000000000_110_1_10)); check("R9", 3'b110, 1'b1, 2'b10);
    apply(vec_t'(19'b10000000110_110_1_10)); check("R9", 3'b110, 1'b1, 2'b10);
    apply(vec_t'(19'b00000000001_000_0_00)); check("R9", 3'b000, 1'b0, 2'b00);
    sticky_err_en = 1'b0;

    // R11 set beats clear in the same cycle
    apply(vec_t'(19'b10000000111_001_1_00)); check("R11", 3'b001, 1'b1, 2'b00);

    // R1 reset mid-transfer
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #5;
    check("R1", 3'b000, 1'b0, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule